// File: doc/BRIEF.md
# Control-Word Register-File Datapath

This block is an execution datapath steered entirely by a single packed control word presented each cycle. A bank of eight 8-bit registers has two combinational read ports, named bus A and bus B, and one synchronous write port. Bus A and bus B (or an external constant in place of bus B) feed a function unit. The function unit holds an adder, a logic unit and a single-position shifter, and an internal selector picks among their results.

The function result, or an external data word, is written back to a chosen destination register at the next clock edge when the write enable field is set. The carry, overflow, zero and negative flags, the address output (bus A) and the data output (bus B) are combinational. They are therefore valid in the same cycle that the control word is presented. A sequencer outside the block supplies one control word per cycle.

Top module: `cwdp_core`

## Requirements
- R1: A synchronous active-low reset clears all eight registers to 0x00.
- R2: The 16-bit control word is packed as dest[15:13], asel[12:10], bsel[9:7], const_sel[6], func[5:2], wb_ext[1], wr_en[0]. Dest, asel and bsel are register numbers 0 to 7.
- R3: `addr_out` equals the register chosen by asel, in the same cycle.
- R4: `data_out` is bus B. It equals `const_in` when const_sel is 1, and otherwise it equals the register chosen by bsel, in the same cycle.
- R5: When wr_en is 1, the register chosen by dest takes the write-back value at the next rising edge. When wr_en is 0, no register changes.
- R6: The write-back value is the function result when wb_ext is 0, and `ext_data` when wb_ext is 1.
- R7: Func values 0 to 7 are arithmetic: result = A + Y + func[0]. Y is 0x00, B, ~B or 0xFF for func[2:1] = 00, 01, 10 or 11. For example, 0101 gives A-B and 0110 gives A-1.
- R8: Func values 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R9: Func values 1100, 1101, 1110 and 1111 give B, B shifted right one place with a 0 fill, B shifted left one place with a 0 fill, and B rotated left one place.
- R10: `flag_z` is 1 when the function result is zero, and `flag_n` is the result's MSB. For arithmetic, `flag_c` is the carry out of bit 7 and `flag_v` is two's-complement overflow. Both are 0 for logic and shift functions.
- R11: A read of the destination register during its own write cycle returns the old value. The new value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Control word for this cycle |
| const_in | input | 8 | Constant that can replace bus B |
| ext_data | input | 8 | External write-back data |
| addr_out | output | 8 | Bus A |
| data_out | output | 8 | Bus B |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bus outputs and all four flags are due in the cycle the control word is applied. The bench drives each word after a falling edge and compares these outputs one nanosecond later, before the next rising edge. A register write is due one cycle later. The reference model commits the write only after that rising edge, so the written value is checked through `addr_out` in a following cycle and never in the cycle of the write.

// File: rtl/cwdp_pkg.sv
// Shared types for the control-word datapath.
// Assumes a 4-bit function code; the top bit separates arithmetic from the rest.
package cwdp_pkg;
    typedef enum logic [3:0] {
        FN_PASS_A  = 4'b0000,
        FN_INC_A   = 4'b0001,
        FN_ADD     = 4'b0010,
        FN_ADD_C   = 4'b0011,
        FN_ADD_NB  = 4'b0100,
        FN_SUB     = 4'b0101,
        FN_DEC_A   = 4'b0110,
        FN_PASS_AC = 4'b0111,
        FN_AND     = 4'b1000,
        FN_OR      = 4'b1001,
        FN_XOR     = 4'b1010,
        FN_NOT_A   = 4'b1011,
        FN_PASS_B  = 4'b1100,
        FN_SRL_B   = 4'b1101,
        FN_SLL_B   = 4'b1110,
        FN_ROL_B   = 4'b1111
    } fn_code_t;

    localparam int FN_W = 4;
endpackage

// File: rtl/cwdp_regfile.sv
// Register bank: two combinational read ports and one synchronous write port.
// Assumes a synchronous active-low reset that clears every entry.
module cwdp_regfile #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] bank [NREG];

    // Clear on reset, otherwise commit one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= '0;
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    // Read ports see the stored value (old value during a write).
    always_comb begin
        rd_a_data = bank[rd_a_addr];
        rd_b_data = bank[rd_b_addr];
    end
endmodule

// File: rtl/cwdp_alu.sv
// Arithmetic and logic unit. Arithmetic: A + Y + fn[0], Y picked by fn[2:1].
// Logic ops are picked by fn[1:0] when fn[3] is set; carry/overflow then read 0.
module cwdp_alu
    import cwdp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  fn_code_t      fn,
    output logic [DW-1:0] result,
    output logic          carry,
    output logic          ovf
);
    logic [DW-1:0] y_sel;
    logic [DW:0]   sum;
    logic [DW-1:0] logic_res;

    // Choose the second adder operand.
    always_comb begin
        case (fn[2:1])
            2'b00:   y_sel = '0;
            2'b01:   y_sel = op_b;
            2'b10:   y_sel = ~op_b;
            default: y_sel = '1;
        endcase
    end

    // Adder with carry-in from the function code.
    always_comb sum = {1'b0, op_a} + {1'b0, y_sel} + {{DW{1'b0}}, fn[0]};

    // Bitwise operations.
    always_comb begin
        case (fn[1:0])
            2'b00:   logic_res = op_a & op_b;
            2'b01:   logic_res = op_a | op_b;
            2'b10:   logic_res = op_a ^ op_b;
            default: logic_res = ~op_a;
        endcase
    end

    // Result and adder flags, flags masked for non-arithmetic codes.
    always_comb begin
        result = fn[3] ? logic_res : sum[DW-1:0];
        carry  = !fn[3] && sum[DW];
        ovf    = !fn[3] && (op_a[DW-1] == y_sel[DW-1]) && (sum[DW-1] != op_a[DW-1]);
    end
endmodule

// File: rtl/cwdp_shift.sv
// One-position shifter on bus B: pass, right with zero fill, left with zero fill,
// rotate left. Assumes sel comes from the low two bits of the function code.
module cwdp_shift #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] din,
    input  logic [1:0]    sel,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] right_v, left_v, rot_v;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == DW - 1) begin : g_top
            assign right_v[i] = 1'b0;
        end else begin : g_mid
            assign right_v[i] = din[i+1];
        end
        if (i == 0) begin : g_low
            assign left_v[i] = 1'b0;
            assign rot_v[i]  = din[DW-1];
        end else begin : g_up
            assign left_v[i] = din[i-1];
            assign rot_v[i]  = din[i-1];
        end
    end

    // Pick the shifted form.
    always_comb begin
        case (sel)
            2'b00:   dout = din;
            2'b01:   dout = right_v;
            2'b10:   dout = left_v;
            default: dout = rot_v;
        endcase
    end
endmodule

// File: rtl/cwdp_core.sv
// Control-word driven datapath: register bank, bus-B source mux, function unit,
// flag logic and write-back mux. Assumes one control word per cycle; writes land
// at the next rising edge, flags and bus outputs are combinational.
module cwdp_core
    import cwdp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3*AW+6:0]     ctrl_word,
    input  logic [DW-1:0]       const_in,
    input  logic [DW-1:0]       ext_data,
    output logic [DW-1:0]       addr_out,
    output logic [DW-1:0]       data_out,
    output logic                flag_c,
    output logic                flag_v,
    output logic                flag_z,
    output logic                flag_n
);
    localparam int CWW     = 3 * AW + 7;
    localparam int DEST_LO = CWW - AW;
    localparam int ASEL_LO = DEST_LO - AW;
    localparam int BSEL_LO = ASEL_LO - AW;
    localparam int CSEL_B  = 6;
    localparam int FN_LO   = 2;
    localparam int WBX_B   = 1;
    localparam int WR_B    = 0;

    logic [AW-1:0] dest, asel, bsel;
    logic          csel, wb_ext, wr_en;
    fn_code_t      fn;
    logic [DW-1:0] bus_a, reg_b, bus_b;
    logic [DW-1:0] alu_res, sh_res, func_res, wb_data;
    logic          alu_c, alu_v;

    // Split the control word into its fields.
    always_comb begin
        dest   = ctrl_word[DEST_LO +: AW];
        asel   = ctrl_word[ASEL_LO +: AW];
        bsel   = ctrl_word[BSEL_LO +: AW];
        csel   = ctrl_word[CSEL_B];
        fn     = fn_code_t'(ctrl_word[FN_LO +: FN_W]);
        wb_ext = ctrl_word[WBX_B];
        wr_en  = ctrl_word[WR_B];
    end

    cwdp_regfile #(.DW(DW), .AW(AW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (dest),
        .wr_data   (wb_data),
        .rd_a_addr (asel),
        .rd_b_addr (bsel),
        .rd_a_data (bus_a),
        .rd_b_data (reg_b)
    );

    // Bus B source: register or external constant.
    always_comb bus_b = csel ? const_in : reg_b;

    cwdp_alu #(.DW(DW)) i_alu (
        .op_a   (bus_a),
        .op_b   (bus_b),
        .fn     (fn),
        .result (alu_res),
        .carry  (alu_c),
        .ovf    (alu_v)
    );

    cwdp_shift #(.DW(DW)) i_shift (
        .din  (bus_b),
        .sel  (fn[1:0]),
        .dout (sh_res)
    );

    // Function selector, write-back mux and status.
    always_comb begin
        func_res = (fn[3:2] == 2'b11) ? sh_res : alu_res;
        wb_data  = wb_ext ? ext_data : func_res;
        flag_c   = alu_c;
        flag_v   = alu_v;
        flag_z   = (func_res == '0);
        flag_n   = func_res[DW-1];
        addr_out = bus_a;
        data_out = bus_b;
    end
endmodule

// File: rtl/cwdp_core_chk.sv
// Property checker for cwdp_core, attached through bind.
// Assumes the default control word packing of the top module.
module cwdp_core_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3*AW+6:0] ctrl_word,
    input logic [DW-1:0]   const_in,
    input logic [DW-1:0]   ext_data,
    input logic [DW-1:0]   addr_out,
    input logic [DW-1:0]   data_out,
    input logic            flag_c,
    input logic            flag_v,
    input logic            flag_z,
    input logic            flag_n,
    input logic [DW-1:0]   func_res
);
    localparam int CWW     = 3 * AW + 7;
    localparam int DEST_LO = CWW - AW;
    localparam int ASEL_LO = DEST_LO - AW;
    localparam int BSEL_LO = ASEL_LO - AW;

    logic [AW-1:0] k_dest, k_asel, k_bsel;
    logic [3:0]    k_fn;
    logic          k_csel, k_wbx, k_wr;

    // Field view for the properties.
    always_comb begin
        k_dest = ctrl_word[DEST_LO +: AW];
        k_asel = ctrl_word[ASEL_LO +: AW];
        k_bsel = ctrl_word[BSEL_LO +: AW];
        k_csel = ctrl_word[6];
        k_fn   = ctrl_word[5:2];
        k_wbx  = ctrl_word[1];
        k_wr   = ctrl_word[0];
    end

    // R5 R11: a write shows up on bus A one cycle later (R6 picks the source).
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(k_wr) && k_asel == $past(k_dest)) |->
        addr_out == ($past(k_wbx) ? $past(ext_data) : $past(func_res)));

    // R5: with writes off, a re-read of the same register is unchanged.
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(k_wr) && k_asel == $past(k_asel)) |->
        $stable(addr_out));

    // R4: constant replaces bus B.
    a_r4_const_bus: assert property (@(posedge clk) disable iff (!rst_n)
        k_csel |-> data_out == const_in);

    // R3 R4: both buses read the same register when selects match.
    a_r4_same_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_csel && k_bsel == k_asel) |-> data_out == addr_out);

    // R10: carry and overflow cleared outside arithmetic.
    a_r10_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        k_fn[3] |-> (!flag_c && !flag_v));

    // R10: zero and negative follow the function result.
    a_r10_zn: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_z == (func_res == '0)) && (flag_n == func_res[DW-1]));

    // R9 R7: pass codes forward the selected bus.
    a_r9_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (k_fn == 4'b1100) |-> func_res == data_out);
    a_r7_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (k_fn == 4'b0000) |-> func_res == addr_out);
endmodule

bind cwdp_core cwdp_core_chk #(.DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_cwdp_core.sv
// Bench for cwdp_core: behavioural reference model, compared every cycle.
module test_cwdp_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [7:0]  const_in = '0;
    logic [7:0]  ext_data = '0;
    logic [7:0]  addr_out, data_out;
    logic        flag_c, flag_v, flag_z, flag_n;

    int n_run = 0;
    int n_fail = 0;
    int model [8];

    always #2 clk = ~clk;

    cwdp_core i_cwdp_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .const_in  (const_in),
        .ext_data  (ext_data),
        .addr_out  (addr_out),
        .data_out  (data_out),
        .flag_c    (flag_c),
        .flag_v    (flag_v),
        .flag_z    (flag_z),
        .flag_n    (flag_n)
    );

    function automatic logic [15:0] mk(int d, int a, int b, int cs, int fn, int wx, int wr);
        return 16'(d * 8192 + a * 1024 + b * 128 + cs * 64 + fn * 4 + wx * 2 + wr);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference function unit: returns f, carry, overflow.
    function automatic void ref_fn(int a, int b, int fn, output int f, output int c, output int v);
        int y, s, sa, sy, sv;
        c = 0; v = 0;
        if (fn < 8) begin
            case ((fn / 2) % 4)
                0: y = 0;
                1: y = b;
                2: y = 255 - b;
                default: y = 255;
            endcase
            s = a + y + (fn % 2);
            f = s % 256;
            c = s / 256;
            sa = (a >= 128) ? a - 256 : a;
            sy = (y >= 128) ? y - 256 : y;
            sv = sa + sy + (fn % 2);
            v = (sv > 127 || sv < -128) ? 1 : 0;
        end else begin
            case (fn)
                8:  f = a & b;
                9:  f = a | b;
                10: f = a ^ b;
                11: f = 255 - a;
                12: f = b;
                13: f = b / 2;
                14: f = (b * 2) % 256;
                default: f = ((b * 2) % 256) + (b / 128);
            endcase
        end
    endfunction

    // Apply one control word, check same-cycle outputs, then commit the model.
    task automatic step(logic [15:0] cw, logic [7:0] k, logic [7:0] x, string req);
        int d, a, b, fn, f, c, v, bus_b, wb;
        @(negedge clk);
        ctrl_word = cw; const_in = k; ext_data = x;
        #1;
        d = int'(cw[15:13]); a = int'(cw[12:10]); b = int'(cw[9:7]); fn = int'(cw[5:2]);
        bus_b = cw[6] ? int'(k) : model[b];
        ref_fn(model[a], bus_b, fn, f, c, v);
        chk(req, "R3 addr_out", int'(addr_out), model[a]);
        chk(req, "R4 data_out", int'(data_out), bus_b);
        chk(req, "R10 flags cvzn", int'({flag_c, flag_v, flag_z, flag_n}),
            c * 8 + v * 4 + ((f == 0) ? 2 : 0) + ((f >= 128) ? 1 : 0));
        wb = cw[1] ? int'(x) : f;
        @(posedge clk);
        if (cw[0]) model[d] = wb;
    endtask

    initial begin
        #(200000 * 4);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int pa [4] = '{8'h7F, 8'h80, 8'h00, 8'hA5};
        int pb [4] = '{8'h01, 8'hFF, 8'h00, 8'h3C};
        for (int i = 0; i < 8; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: all registers read zero after reset.
        for (int i = 0; i < 8; i++) step(mk(0, i, i, 0, 0, 0, 0), 8'h00, 8'hEE, "R1");

        // R6: load every register from ext_data.
        for (int i = 0; i < 8; i++) step(mk(i, 0, 0, 0, 0, 1, 1), 8'h00, 8'(17 * i + 3), "R6");
        for (int i = 0; i < 8; i++) step(mk(0, i, 7 - i, 0, 0, 0, 0), 8'h00, 8'h00, "R6");

        // R2: r1 <= r2 + ~r3 + 1 through the packed fields, then read r1.
        step(mk(1, 2, 3, 0, 5, 0, 1), 8'h00, 8'h00, "R2");
        step(mk(0, 1, 1, 0, 0, 0, 0), 8'h00, 8'h00, "R2");

        // R4: constant on bus B, written back through the adder.
        step(mk(6, 4, 2, 1, 2, 0, 1), 8'hC3, 8'h00, "R4");
        step(mk(0, 6, 6, 1, 12, 0, 0), 8'h5E, 8'h00, "R4");

        // R5: write disabled leaves the register as it was.
        step(mk(4, 4, 4, 0, 11, 1, 0), 8'h00, 8'hAA, "R5");
        step(mk(0, 4, 4, 0, 0, 0, 0), 8'h00, 8'h00, "R5");

        // R11: same-cycle read of the destination gives the old value.
        step(mk(5, 5, 5, 0, 0, 1, 1), 8'h00, 8'h5A, "R11");
        step(mk(0, 5, 5, 0, 0, 0, 0), 8'h00, 8'h00, "R11");

        // R7 R8 R9: every function code on corner operand pairs.
        for (int p = 0; p < 4; p++) begin
            step(mk(0, 0, 0, 0, 0, 1, 1), 8'h00, 8'(pa[p]), "R6");
            step(mk(1, 0, 0, 0, 0, 1, 1), 8'h00, 8'(pb[p]), "R6");
            for (int fn = 0; fn < 16; fn++) begin
                step(mk(7, 0, 1, 0, fn, 0, 1), 8'h00, 8'h00, (fn < 8) ? "R7" : (fn < 12) ? "R8" : "R9");
                step(mk(0, 7, 1, 0, 0, 0, 0), 8'h00, 8'h00, (fn < 8) ? "R7" : (fn < 12) ? "R8" : "R9");
            end
        end

        // Mixed stream of arbitrary control words (R10 flags on each).
        for (int t = 0; t < 600; t++)
            step(16'($urandom), 8'($urandom), 8'($urandom), "R10");

        // R5: final read-back of the whole bank.
        for (int i = 0; i < 8; i++) step(mk(0, i, i, 0, 0, 0, 0), 8'h00, 8'h00, "R5");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule